// File: doc/BRIEF.md
# Complementary PWM Timer with Dead Time

This block is one 16-bit timer channel that serves as an interval counter, an event timestamper and a PWM generator in a single unit. The counter advances on each cycle in which the count enable is high and runs from zero up to a programmable period. At that terminal count it either wraps back to zero (reload mode) or freezes at the period (one-shot mode) until a restart pulse. A rising edge on the capture input is synchronized and stores the running count. A second capture that arrives before software has acknowledged the first raises an overflow flag.

The PWM waveform is high while the count is below the compare value. A true output follows this waveform and a complementary output follows its inverse. Each output's rising edge is delayed by a programmable number of clock cycles, so the two outputs are never high together. New period and compare values are held in a staging register and only take effect at the terminal count, so a write in mid-period cannot produce a runt pulse.

A kill input overrides both outputs with separately chosen safe levels. The override acts through logic alone, with no clock edge involved. After kill is released the safe levels stay in force until the next period boundary, so that normal switching always resumes at a clean cycle start.

Top module: `cpwm_dt_timer`

## Requirements
- R1: Reset clears the count to 0. The count rises by exactly 1 at each clock edge where `cnt_en` is 1, and does not change at edges where `cnt_en` is 0.
- R2: In reload mode (`oneshot`=0), an edge where the count equals the active period sets the count to 0. `tc_flag` is 1 for exactly the one cycle that follows that edge.
- R3: In one-shot mode (`oneshot`=1), the count stops at the active period and `tc_flag` pulses only once. A `restart` pulse sets the count to 0 at the next edge and counting resumes.
- R4: A rising edge on `cap_in` stores the count into `cap_val` three clock edges later and sets `cap_valid`. The stored count is the value the count held two edges after the input rose. Holding `cap_in` high does not capture again.
- R5: A capture while `cap_valid` is 1 and `cap_rd` is 0 sets `cap_ovf`. A `cap_rd` pulse clears both `cap_valid` and `cap_ovf`.
- R6: The PWM waveform is 1 while count < compare. With a period register P, compare C and dead time D, each period of P+1 cycles has `out_p` high for max(C-D,0) cycles and `out_n` high for max(P+1-C-D,0) cycles.
- R7: `dead_in` delays only the rising edge of each output, by that many clock cycles. A pulse that is no longer than the dead time leaves the output low for its whole length.
- R8: When no kill is in force, `out_p` and `out_n` are never both 1.
- R9: Writes through `per_wr`/`per_in` and `cmp_wr`/`cmp_in` do not change the current period. They take effect at the next terminal count.
- R10: While `kill` is 1, `out_p` equals `kill_lvl_p` and `out_n` equals `kill_lvl_n`, with no clock edge needed. The two levels are set independently.
- R11: After `kill` falls, the kill levels stay on the outputs until the terminal count that follows. After that, normal PWM resumes.
- R12: `cmp_flag` is 1 for the one cycle that follows an enabled edge at which the count equalled the active compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable |
| restart | input | 1 | Clears the count and leaves the one-shot stop |
| oneshot | input | 1 | 1 = stop at period, 0 = reload |
| per_wr | input | 1 | Stage a new period |
| per_in | input | 16 | Period value |
| cmp_wr | input | 1 | Stage a new compare |
| cmp_in | input | 16 | Compare value |
| dead_in | input | 8 | Dead time in clock cycles |
| kill | input | 1 | Asynchronous output override |
| kill_lvl_p | input | 1 | Safe level for the true output |
| kill_lvl_n | input | 1 | Safe level for the complementary output |
| cap_in | input | 1 | Capture event (asynchronous) |
| cap_rd | input | 1 | Acknowledge the capture |
| out_p | output | 1 | True PWM output |
| out_n | output | 1 | Complementary PWM output |
| count | output | 16 | Current count |
| cap_val | output | 16 | Captured count |
| cap_valid | output | 1 | Capture holds unread data |
| cap_ovf | output | 1 | Capture overwritten before it was read |
| tc_flag | output | 1 | Terminal-count pulse |
| cmp_flag | output | 1 | Compare-match pulse |

## Verification
A corrupted active period or compare register shows up within one period, as a wrong wrap point on `count` and a wrong number of high cycles on the outputs. A stuck dead-time counter shows up either as an output that never rises or as a window in which both outputs are high. A kill latch that does not clear at the boundary leaves the safe levels on the pins for a full period or longer after release, and the bench looks for this. A lost capture edge or a flag that is not cleared is visible at the capture port three cycles after the stimulus.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic {
    MODE_RELOAD  = 1'b0,
    MODE_ONESHOT = 1'b1
  } cnt_mode_e;

  typedef struct packed {
    logic p;
    logic n;
  } lvl_pair_t;
endpackage

// File: rtl/cpwm_counter.sv
module cpwm_counter
  import cpwm_pkg::*;
#(
  parameter int W = 16,
  parameter logic [W-1:0] PER_RST = 9,
  parameter logic [W-1:0] CMP_RST = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic         restart,
  input  cnt_mode_e    mode,
  input  logic         per_wr,
  input  logic [W-1:0] per_in,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_in,
  output logic [W-1:0] count,
  output logic [W-1:0] per_act,
  output logic [W-1:0] cmp_act,
  output logic         halted,
  output logic         tc_pulse,
  output logic         cmp_pulse
);
  logic [W-1:0] count_q, per_buf_q, per_act_q, cmp_buf_q, cmp_act_q;
  logic         halted_q, tc_q, cmp_q;
  logic         tick, at_end;

  assign tick   = cnt_en & ~halted_q;
  assign at_end = (count_q >= per_act_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q   <= '0;
      per_buf_q <= PER_RST;
      per_act_q <= PER_RST;
      cmp_buf_q <= CMP_RST;
      cmp_act_q <= CMP_RST;
      halted_q  <= 1'b0;
      tc_q      <= 1'b0;
      cmp_q     <= 1'b0;
    end else begin
      tc_q  <= 1'b0;
      cmp_q <= 1'b0;
      if (per_wr) per_buf_q <= per_in;
      if (cmp_wr) cmp_buf_q <= cmp_in;
      if (restart) begin
        count_q  <= '0;
        halted_q <= 1'b0;
      end else if (tick) begin
        cmp_q <= (count_q == cmp_act_q);
        if (at_end) begin
          tc_q      <= 1'b1;
          per_act_q <= per_wr ? per_in : per_buf_q;
          cmp_act_q <= cmp_wr ? cmp_in : cmp_buf_q;
          if (mode == MODE_ONESHOT) halted_q <= 1'b1;
          else                      count_q  <= '0;
        end else begin
          count_q <= count_q + 1'b1;
        end
      end
    end
  end

  assign count     = count_q;
  assign per_act   = per_act_q;
  assign cmp_act   = cmp_act_q;
  assign halted    = halted_q;
  assign tc_pulse  = tc_q;
  assign cmp_pulse = cmp_q;
endmodule

// File: rtl/cpwm_capture.sv
module cpwm_capture #(
  parameter int W = 16,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_in,
  input  logic         cap_rd,
  input  logic [W-1:0] count,
  output logic [W-1:0] cap_val,
  output logic         cap_valid,
  output logic         cap_ovf
);
  localparam int SW = SYNC + 1;

  logic [SW-1:0] sync_q;
  logic [W-1:0]  val_q;
  logic          valid_q, ovf_q, edge_hit;

  assign edge_hit = sync_q[SYNC-1] & ~sync_q[SYNC];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '0;
      val_q   <= '0;
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      sync_q <= {sync_q[SW-2:0], cap_in};
      if (edge_hit) begin
        val_q   <= count;
        valid_q <= 1'b1;
        ovf_q   <= cap_rd ? 1'b0 : (ovf_q | valid_q);
      end else if (cap_rd) begin
        valid_q <= 1'b0;
        ovf_q   <= 1'b0;
      end
    end
  end

  assign cap_val   = val_q;
  assign cap_valid = valid_q;
  assign cap_ovf   = ovf_q;
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] dead,
  input  logic          din,
  output logic          dout
);
  logic [DW-1:0] wait_q;
  logic          out_q;

  always_ff @(posedge clk) begin
    if (rst || !din) begin
      wait_q <= '0;
      out_q  <= 1'b0;
    end else if (!out_q) begin
      if (wait_q == dead) out_q  <= 1'b1;
      else                wait_q <= wait_q + 1'b1;
    end
  end

  assign dout = out_q;
endmodule

// File: rtl/cpwm_dt_timer.sv
module cpwm_dt_timer
  import cpwm_pkg::*;
#(
  parameter int W  = 16,
  parameter int DW = 8,
  parameter logic [W-1:0] PER_RST = 9,
  parameter logic [W-1:0] CMP_RST = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_en,
  input  logic          restart,
  input  logic          oneshot,
  input  logic          per_wr,
  input  logic [W-1:0]  per_in,
  input  logic          cmp_wr,
  input  logic [W-1:0]  cmp_in,
  input  logic [DW-1:0] dead_in,
  input  logic          kill,
  input  logic          kill_lvl_p,
  input  logic          kill_lvl_n,
  input  logic          cap_in,
  input  logic          cap_rd,
  output logic          out_p,
  output logic          out_n,
  output logic [W-1:0]  count,
  output logic [W-1:0]  cap_val,
  output logic          cap_valid,
  output logic          cap_ovf,
  output logic          tc_flag,
  output logic          cmp_flag
);
  localparam int SIDES = 2;

  logic [W-1:0]     cmp_act_w, per_act_w;
  logic             halted_w, pwm_raw;
  logic [SIDES-1:0] side_in, side_out;
  logic [1:0]       ksync_q;
  logic             kill_hold_q, force_kill;
  lvl_pair_t        safe_lvl;

  cpwm_counter #(.W(W), .PER_RST(PER_RST), .CMP_RST(CMP_RST)) cnt_i (
    .clk       (clk),
    .rst       (rst),
    .cnt_en    (cnt_en),
    .restart   (restart),
    .mode      (cnt_mode_e'(oneshot)),
    .per_wr    (per_wr),
    .per_in    (per_in),
    .cmp_wr    (cmp_wr),
    .cmp_in    (cmp_in),
    .count     (count),
    .per_act   (per_act_w),
    .cmp_act   (cmp_act_w),
    .halted    (halted_w),
    .tc_pulse  (tc_flag),
    .cmp_pulse (cmp_flag)
  );

  cpwm_capture #(.W(W)) cap_i (
    .clk       (clk),
    .rst       (rst),
    .cap_in    (cap_in),
    .cap_rd    (cap_rd),
    .count     (count),
    .cap_val   (cap_val),
    .cap_valid (cap_valid),
    .cap_ovf   (cap_ovf)
  );

  assign pwm_raw = (count < cmp_act_w);
  assign side_in = {~pwm_raw, pwm_raw};

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    cpwm_deadband #(.DW(DW)) db_i (
      .clk  (clk),
      .rst  (rst),
      .dead (dead_in),
      .din  (side_in[s]),
      .dout (side_out[s])
    );
  end

  // kill latch: set from the synchronized input, released only at a period boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      ksync_q     <= '0;
      kill_hold_q <= 1'b0;
    end else begin
      ksync_q <= {ksync_q[0], kill};
      if (ksync_q[1])
        kill_hold_q <= 1'b1;
      else if ((tc_flag || restart) && !kill && !ksync_q[0])
        kill_hold_q <= 1'b0;
    end
  end

  assign force_kill = kill | ksync_q[0] | ksync_q[1] | kill_hold_q;
  assign safe_lvl   = '{p: kill_lvl_p, n: kill_lvl_n};
  assign out_p      = force_kill ? safe_lvl.p : side_out[0];
  assign out_n      = force_kill ? safe_lvl.n : side_out[1];
endmodule

// File: rtl/cpwm_dt_timer_chk.sv
module cpwm_dt_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         cnt_en,
  input logic         restart,
  input logic         kill,
  input logic         kill_lvl_p,
  input logic         kill_lvl_n,
  input logic         out_p,
  input logic         out_n,
  input logic [W-1:0] count,
  input logic         cap_valid,
  input logic         cap_ovf,
  input logic [W-1:0] per_act,
  input logic         halted,
  input logic         force_kill
);
  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !restart && !halted && count < per_act) |=> (count == $past(count) + W'(1)));

  // R1
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !restart) |=> $stable(count));

  // R3
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (halted && !restart) |=> $stable(count));

  // R5
  cap_ovf_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cap_ovf) |-> $past(cap_valid));

  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !force_kill |-> !(out_p && out_n));

  // R10
  kill_level_chk: assert property (@(posedge clk) disable iff (rst)
    kill |-> (out_p == kill_lvl_p && out_n == kill_lvl_n));
endmodule

bind cpwm_dt_timer cpwm_dt_timer_chk #(.W(W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .cnt_en     (cnt_en),
  .restart    (restart),
  .kill       (kill),
  .kill_lvl_p (kill_lvl_p),
  .kill_lvl_n (kill_lvl_n),
  .out_p      (out_p),
  .out_n      (out_n),
  .count      (count),
  .cap_valid  (cap_valid),
  .cap_ovf    (cap_ovf),
  .per_act    (per_act_w),
  .halted     (halted_w),
  .force_kill (force_kill)
);

// File: tb/cpwm_dt_timer_tb.sv
module cpwm_dt_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0, restart = 1'b0, oneshot = 1'b0;
  logic        per_wr = 1'b0, cmp_wr = 1'b0;
  logic [15:0] per_in = '0, cmp_in = '0;
  logic [7:0]  dead_in = '0;
  logic        kill = 1'b0, kill_lvl_p = 1'b0, kill_lvl_n = 1'b0;
  logic        cap_in = 1'b0, cap_rd = 1'b0;
  logic        out_p, out_n, cap_valid, cap_ovf, tc_flag, cmp_flag;
  logic [15:0] count, cap_val;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cpwm_dt_timer dut_i (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .restart(restart), .oneshot(oneshot),
    .per_wr(per_wr), .per_in(per_in), .cmp_wr(cmp_wr), .cmp_in(cmp_in),
    .dead_in(dead_in), .kill(kill), .kill_lvl_p(kill_lvl_p), .kill_lvl_n(kill_lvl_n),
    .cap_in(cap_in), .cap_rd(cap_rd), .out_p(out_p), .out_n(out_n), .count(count),
    .cap_val(cap_val), .cap_valid(cap_valid), .cap_ovf(cap_ovf),
    .tc_flag(tc_flag), .cmp_flag(cmp_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_tc(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!tc_flag && n < 200);
  endtask

  task automatic window(output int hp, output int hn, output int both);
    hp = 0; hn = 0; both = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      hp += int'(out_p);
      hn += int'(out_n);
      if (out_p && out_n) both++;
    end
  endtask

  task automatic t_reset();
    step(3);
    chk("R1 reset count", int'(count), 0);
    chk("R8 reset out_p", int'(out_p), 0);
    chk("R8 reset out_n", int'(out_n), 0);
    chk("R4 reset cap_valid", int'(cap_valid), 0);
  endtask

  task automatic t_reload();
    rst = 1'b0;
    cnt_en = 1'b1;
    for (int k = 1; k <= 25; k++) begin
      step();
      chk("R1 count sequence", int'(count), k % 10);
      chk("R2 tc pulse", int'(tc_flag), (k % 10 == 0) ? 1 : 0);
      chk("R12 cmp pulse", int'(cmp_flag), (k % 10 == 5) ? 1 : 0);
    end
  endtask

  task automatic t_enable();
    int c;
    cnt_en = 1'b0;
    step();
    c = int'(count);
    for (int i = 0; i < 5; i++) begin
      step();
      chk("R1 hold when disabled", int'(count), c);
    end
    cnt_en = 1'b1;
  endtask

  task automatic t_pwm(input int dt, input int ep, input int en);
    int hp, hn, both;
    dead_in = 8'(dt);
    step(25);
    window(hp, hn, both);
    chk("R6 R7 true highs", hp, ep);
    chk("R6 R7 comp highs", hn, en);
    chk("R8 overlap", both, 0);
  endtask

  task automatic t_buffered();
    int n, hp, hn, both;
    dead_in = 8'd0;
    step(25);
    wait_tc(n);
    cmp_in = 16'd7;
    cmp_wr = 1'b1;
    step();
    cmp_wr = 1'b0;
    hp = int'(out_p);
    hn = int'(out_n);
    for (int i = 1; i < 10; i++) begin
      step();
      hp += int'(out_p);
      hn += int'(out_n);
    end
    chk("R9 compare held in current period", hp, 4);
    window(hp, hn, both);
    chk("R9 new compare true", hp, 7);
    chk("R9 new compare comp", hn, 3);
    cmp_in = 16'd4;
    cmp_wr = 1'b1;
    step();
    cmp_wr = 1'b0;
    step(25);
  endtask

  task automatic t_period();
    int n;
    wait_tc(n);
    per_in = 16'd5;
    per_wr = 1'b1;
    step();
    per_wr = 1'b0;
    n = 1;
    while (!tc_flag && n < 200) begin
      step();
      n++;
    end
    chk("R9 old period kept", n, 10);
    wait_tc(n);
    chk("R9 new period length", n, 6);
    per_in = 16'd9;
    per_wr = 1'b1;
    step();
    per_wr = 1'b0;
    wait_tc(n);
    wait_tc(n);
    chk("R2 restored period", n, 10);
  endtask

  task automatic t_oneshot();
    int tcs = 0;
    oneshot = 1'b1;
    for (int i = 0; i < 30; i++) begin
      step();
      tcs += int'(tc_flag);
    end
    chk("R3 stopped at period", int'(count), 9);
    chk("R3 single tc", tcs, 1);
    step(3);
    chk("R3 still stopped", int'(count), 9);
    restart = 1'b1;
    oneshot = 1'b0;
    step();
    restart = 1'b0;
    chk("R3 restart clears", int'(count), 0);
    step();
    chk("R3 counting resumes", int'(count), 1);
    step(25);
  endtask

  task automatic t_capture();
    int c0, v;
    cap_rd = 1'b1;
    step();
    cap_rd = 1'b0;
    step();
    c0 = int'(count);
    cap_in = 1'b1;
    step(2);
    chk("R4 not yet valid", int'(cap_valid), 0);
    step();
    chk("R4 valid", int'(cap_valid), 1);
    chk("R4 captured count", int'(cap_val), (c0 + 2) % 10);
    v = int'(cap_val);
    step(5);
    chk("R4 level ignored", int'(cap_val), v);
    chk("R5 no ovf on single", int'(cap_ovf), 0);
    cap_in = 1'b0;
    step(3);
    cap_in = 1'b1;
    step(4);
    chk("R5 overflow set", int'(cap_ovf), 1);
    chk("R5 still valid", int'(cap_valid), 1);
    cap_in = 1'b0;
    cap_rd = 1'b1;
    step();
    cap_rd = 1'b0;
    chk("R5 read clears valid", int'(cap_valid), 0);
    chk("R5 read clears ovf", int'(cap_ovf), 0);
  endtask

  task automatic t_kill();
    int n, hp, hn, both, bad;
    kill_lvl_p = 1'b0;
    kill_lvl_n = 1'b1;
    wait_tc(n);
    step();
    kill = 1'b1;
    #1;
    chk("R10 async true level", int'(out_p), 0);
    chk("R10 async comp level", int'(out_n), 1);
    step(4);
    kill_lvl_p = 1'b1;
    kill_lvl_n = 1'b1;
    #1;
    chk("R10 separate true level", int'(out_p), 1);
    chk("R10 separate comp level", int'(out_n), 1);
    kill_lvl_p = 1'b0;
    kill_lvl_n = 1'b1;
    wait_tc(n);
    kill = 1'b0;
    bad = 0;
    for (int i = 0; i < 5; i++) begin
      step();
      if (out_p != 1'b0 || out_n != 1'b1) bad++;
    end
    chk("R11 levels held after release", bad, 0);
    wait_tc(n);
    step(12);
    window(hp, hn, both);
    chk("R11 resume true", hp, 4);
    chk("R11 resume comp", hn, 6);
  endtask

  initial begin
    t_reset();
    t_reload();
    t_enable();
    t_pwm(0, 4, 6);
    t_pwm(2, 2, 4);
    t_pwm(4, 0, 2);
    t_pwm(5, 0, 1);
    t_buffered();
    t_period();
    t_oneshot();
    t_capture();
    t_kill();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule